// File: doc/BRIEF.md
# Speculative-Return Load Cache with Late Tag Check

This block is a direct-mapped load cache that sends load data onward before it knows the data is correct. A load request is indexed straight from the low virtual-address bits above the line offset. The selected word is read from the data array, the addressed byte or halfword is shifted down to bit 0, and the result appears on the speculative data output one cycle after the request is accepted. In the same lookup the tag array is read. One cycle later the stored tag is compared with the upper address bits, and the block either confirms the load or raises a replay.

A replay means the consumer must throw away the speculative value. The cache then fetches the whole 64-byte line from a memory port, one word per beat, and holds off new requests with a busy output until the line is installed. Any load that was already in the speculative stage when the replay was raised is dropped. The requester is expected to reissue from the replayed load onward, and the reissued load then hits.

Top module: `spec_load_cache`

## Requirements
- R1: After reset the busy, speculative-valid, hit, replay and memory-request outputs are low, and no line is valid, so the first load to any index raises a replay.
- R2: A request presented while busy is low is accepted, and spec_valid is high in the cycle right after acceptance.
- R3: spec_data is the loaded value moved down to bit 0 and zero-extended. The size code is 00 for a byte (the byte selected by address bits 1:0), 01 for a halfword (selected by address bit 1, with bit 0 ignored), and 10 or 11 for a full word.
- R4: Exactly one of chk_hit and replay is high in the cycle after spec_valid for a load that is not dropped. They are never high together.
- R5: The line index is address bits 9:6 and the tag is bits 31:10. A load whose index holds a valid line with the same tag hits. A load with a different tag, or to an empty index, replays.
- R6: One cycle after a replay, mem_req is high for exactly one cycle, with mem_addr equal to the missing address with bits 5:0 cleared. The refill takes 16 beats on mem_rvalid, and beat i carries the word at byte offset 4·i of the line.
- R7: busy is high from the replay cycle until the cycle after the last refill beat. A request made while busy is high is ignored and produces no spec_valid.
- R8: A load that is in the speculative stage when a replay is raised is dropped, and neither chk_hit nor replay is raised for it.
- R9: After the refill completes, busy is low, and a reissued load to the refilled line hits and returns the memory data.
- R10: Hitting loads can be accepted on consecutive cycles. Each one returns its own data and its own hit indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_addr | input | 32 | Virtual byte address of the load |
| req_size | input | 2 | Load size code (00 byte, 01 halfword, 1x word) |
| busy | output | 1 | Requests are not accepted this cycle |
| spec_valid | output | 1 | Speculative load data is on spec_data |
| spec_data | output | 32 | Aligned, zero-extended speculative data |
| chk_hit | output | 1 | Late tag check confirms the load from two cycles ago |
| replay | output | 1 | Late tag check failed; the load and its successors must be reissued |
| mem_req | output | 1 | One-cycle line fetch request |
| mem_addr | output | 32 | Line-aligned fetch address |
| mem_rvalid | input | 1 | Refill beat valid |
| mem_rdata | input | 32 | Refill beat data |

## Verification
The main lookup is driven with several kinds of access. There are byte, halfword and word loads at each offset within a word, which separate the shifter's lane selection and zero extension. Cold misses, repeat hits within a line and the last word of a line show whether index and word offset are taken from the right bits. Same-index loads with different tags distinguish a true tag compare from an index-only match, and show that an eviction removes the old line. Further patterns cover a hit pipelined right behind a miss, which exercises the drop of the younger load, a request made during a refill, which checks the hold-off, and three back-to-back hits, which check that each load gets its own data and indication.

// File: rtl/slc_pkg.sv
package slc_pkg;

  typedef enum logic [1:0] {
    LD_BYTE = 2'b00,
    LD_HALF = 2'b01,
    LD_WORD = 2'b10,
    LD_WIDE = 2'b11
  } ld_size_e;

  typedef enum logic [1:0] {
    RF_IDLE = 2'b00,
    RF_REQ  = 2'b01,
    RF_FILL = 2'b10
  } rf_state_e;

  // Move the addressed lane of a 32-bit word to bit 0 and zero-extend it.
  function automatic logic [31:0] align_load(input logic [31:0] word,
                                             input logic [1:0]  lo,
                                             input logic [1:0]  size);
    logic [4:0]  shamt;
    logic [31:0] moved;
    logic [31:0] res;
    shamt = {lo[1], (size == LD_BYTE) ? lo[0] : 1'b0, 3'b000};
    moved = word >> shamt;
    case (ld_size_e'(size))
      LD_BYTE: res = {24'h0, moved[7:0]};
      LD_HALF: res = {16'h0, moved[15:0]};
      default: res = word;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/slc_tag_store.sv
module slc_tag_store #(
  parameter int INDEX_W = 4,
  parameter int TAG_W   = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] rd_idx,
  output logic [TAG_W-1:0]   rd_tag,
  output logic               rd_vld,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]   wr_tag
);
  localparam int SETS = 2 ** INDEX_W;

  logic [TAG_W-1:0] tags [SETS];
  logic [SETS-1:0]  line_vld;

  always_ff @(posedge clk) begin
    if (wr_en) tags[wr_idx] <= wr_tag;
    rd_tag <= tags[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_vld <= '0;
      rd_vld   <= 1'b0;
    end else begin
      if (wr_en) line_vld[wr_idx] <= 1'b1;
      rd_vld <= line_vld[rd_idx];
    end
  end
endmodule

// File: rtl/slc_data_store.sv
module slc_data_store #(
  parameter int AW     = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data
);
  localparam int DEPTH = 2 ** AW;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/slc_refill_ctrl.sv
module slc_refill_ctrl
  import slc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int INDEX_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [ADDR_W-OFFSET_W-1:0]  miss_line,
  output logic                        active,
  output logic                        mem_req,
  output logic [ADDR_W-1:0]           mem_addr,
  input  logic                        mem_rvalid,
  input  logic [31:0]                 mem_rdata,
  output logic                        wr_en,
  output logic [INDEX_W+OFFSET_W-3:0] wr_addr,
  output logic [31:0]                 wr_data,
  output logic                        fill_done,
  output logic [INDEX_W-1:0]          fill_idx,
  output logic [ADDR_W-OFFSET_W-INDEX_W-1:0] fill_tag
);
  localparam int WOFF_W = OFFSET_W - 2;
  localparam int LINE_W = ADDR_W - OFFSET_W;

  rf_state_e         state;
  logic [LINE_W-1:0] line_q;
  logic [WOFF_W-1:0] beat_q;

  assign active    = (state != RF_IDLE);
  assign mem_req   = (state == RF_REQ);
  assign mem_addr  = {line_q, {OFFSET_W{1'b0}}};
  assign wr_en     = (state == RF_FILL) && mem_rvalid;
  assign fill_idx  = line_q[INDEX_W-1:0];
  assign fill_tag  = line_q[LINE_W-1:INDEX_W];
  assign wr_addr   = {fill_idx, beat_q};
  assign wr_data   = mem_rdata;
  assign fill_done = wr_en && (&beat_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= RF_IDLE;
      line_q <= '0;
      beat_q <= '0;
    end else begin
      case (state)
        RF_IDLE: if (start) begin
          state  <= RF_REQ;
          line_q <= miss_line;
          beat_q <= '0;
        end
        RF_REQ:  state <= RF_FILL;
        RF_FILL: if (wr_en) begin
          beat_q <= beat_q + 1'b1;
          if (&beat_q) state <= RF_IDLE;
        end
        default: state <= RF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spec_load_cache.sv
module spec_load_cache
  import slc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int INDEX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              busy,
  output logic              spec_valid,
  output logic [31:0]       spec_data,
  output logic              chk_hit,
  output logic              replay,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata
);
  localparam int TAG_W  = ADDR_W - OFFSET_W - INDEX_W;
  localparam int LINE_W = ADDR_W - OFFSET_W;
  localparam int DA_W   = INDEX_W + OFFSET_W - 2;

  // Named internal events (also used by the bound checker).
  logic accept, tag_match, flush, refill_active, fill_done;

  // Stage 1: speculative read
  logic              s1_valid;
  logic [LINE_W-1:0] s1_line;
  logic [1:0]        s1_lo;
  logic [1:0]        s1_size;
  // Stage 2: late check
  logic              s2_valid, s2_hit;
  logic [LINE_W-1:0] s2_line;

  logic [31:0]        rd_word;
  logic [TAG_W-1:0]   rd_tag;
  logic               rd_vld;
  logic               wr_en;
  logic [DA_W-1:0]    wr_addr;
  logic [31:0]        wr_data;
  logic [INDEX_W-1:0] fill_idx;
  logic [TAG_W-1:0]   fill_tag;

  assign busy   = replay | refill_active;
  assign accept = req_valid & ~busy;
  assign flush  = replay;

  slc_data_store #(.AW(DA_W), .WORD_W(32)) u_data (
    .clk     (clk),
    .rd_addr (req_addr[OFFSET_W+INDEX_W-1:2]),
    .rd_data (rd_word),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  slc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (req_addr[OFFSET_W+INDEX_W-1:OFFSET_W]),
    .rd_tag (rd_tag),
    .rd_vld (rd_vld),
    .wr_en  (fill_done),
    .wr_idx (fill_idx),
    .wr_tag (fill_tag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_line  <= '0;
      s1_lo    <= '0;
      s1_size  <= '0;
      s2_valid <= 1'b0;
      s2_hit   <= 1'b0;
      s2_line  <= '0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        s1_line <= req_addr[ADDR_W-1:OFFSET_W];
        s1_lo   <= req_addr[1:0];
        s1_size <= req_size;
      end
      s2_valid <= s1_valid & ~flush;
      s2_hit   <= tag_match;
      s2_line  <= s1_line;
    end
  end

  assign spec_valid = s1_valid;
  assign spec_data  = align_load(rd_word, s1_lo, s1_size);
  assign tag_match  = rd_vld && (rd_tag == s1_line[LINE_W-1:INDEX_W]);
  assign chk_hit    = s2_valid & s2_hit;
  assign replay     = s2_valid & ~s2_hit;

  slc_refill_ctrl #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .INDEX_W(INDEX_W)) u_refill (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (replay),
    .miss_line  (s2_line),
    .active     (refill_active),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .fill_done  (fill_done),
    .fill_idx   (fill_idx),
    .fill_tag   (fill_tag)
  );
endmodule

// File: rtl/spec_load_cache_chk.sv
module spec_load_cache_chk #(
  parameter int OFFSET_W = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                busy,
  input logic                spec_valid,
  input logic                chk_hit,
  input logic                replay,
  input logic                mem_req,
  input logic [OFFSET_W-1:0] mem_addr_lo,
  input logic                fill_done
);
  AST_SPEC_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> spec_valid);                       // R2
  AST_NO_SPEC_UNLESS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    spec_valid |-> $past(req_valid && !busy));                  // R7
  AST_CHECK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(chk_hit && replay));                                      // R4
  AST_CHECK_FOLLOWS_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_hit || replay) |-> $past(spec_valid));                 // R4
  AST_FETCH_AFTER_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    replay |=> mem_req);                                        // R6
  AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);                                      // R6
  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr_lo == '0));                           // R6
  AST_BUSY_IN_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (replay || mem_req) |-> busy);                              // R7
  AST_YOUNGER_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    replay |=> !(chk_hit || replay));                           // R8
  AST_FILL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !busy);                                       // R9
endmodule

bind spec_load_cache spec_load_cache_chk #(.OFFSET_W(OFFSET_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .busy        (busy),
  .spec_valid  (spec_valid),
  .chk_hit     (chk_hit),
  .replay      (replay),
  .mem_req     (mem_req),
  .mem_addr_lo (mem_addr[OFFSET_W-1:0]),
  .fill_done   (fill_done)
);

// File: tb/spec_load_cache_bench.sv
module spec_load_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        busy, spec_valid, chk_hit, replay, mem_req;
  logic [31:0] spec_data, mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  spec_load_cache u_spec_load_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .busy(busy), .spec_valid(spec_valid), .spec_data(spec_data),
    .chk_hit(chk_hit), .replay(replay), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] byte_addr);
    logic [31:0] wa;
    wa = byte_addr >> 2;
    return (wa * 32'h9E37_79B1) ^ 32'h5A5A_5A5A;
  endfunction

  // Reference lane extraction, written independently of the design.
  function automatic logic [31:0] expect_load(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] w;
    w = mem_word(a);
    if (sz == 2'b00) begin
      case (a[1:0])
        2'd0: return {24'h0, w[7:0]};
        2'd1: return {24'h0, w[15:8]};
        2'd2: return {24'h0, w[23:16]};
        default: return {24'h0, w[31:24]};
      endcase
    end else if (sz == 2'b01) begin
      return a[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
    end
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Memory model: fixed latency, then 16 consecutive beats.
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        logic [31:0] base;
        base = mem_addr;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem_word(base + 32'(4 * i));
          @(negedge clk);
        end
        mem_rvalid = 1'b0;
      end
    end
  end

  // One lookup: issue, check speculative data, check late result.
  task automatic one_access(input logic [31:0] a, input logic [1:0] sz, input bit exp_hit);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    check(spec_valid == 1'b1, "R2 spec_valid", 32'(spec_valid), 32'd1);
    if (exp_hit)
      check(spec_data == expect_load(a, sz), "R3 spec_data", spec_data, expect_load(a, sz));
    @(negedge clk);
    check(chk_hit == exp_hit, "R5 chk_hit", 32'(chk_hit), 32'(exp_hit));
    check(replay == !exp_hit, "R4 replay", 32'(replay), 32'(!exp_hit));
  endtask

  task automatic do_load(input logic [31:0] a, input logic [1:0] sz, input bit exp_hit);
    one_access(a, sz, exp_hit);
    if (!exp_hit) begin
      @(negedge clk);
      check(mem_req == 1'b1, "R6 mem_req", 32'(mem_req), 32'd1);
      check(mem_addr == {a[31:6], 6'b0}, "R6 mem_addr", mem_addr, {a[31:6], 6'b0});
      check(busy == 1'b1, "R7 busy", 32'(busy), 32'd1);
      @(negedge clk);
      check(mem_req == 1'b0, "R6 pulse", 32'(mem_req), 32'd0);
      while (busy) @(negedge clk);
      one_access(a, sz, 1'b1);  // R9 reissue hits
    end
  endtask

  // Vector: {address, size, expected hit}
  localparam logic [34:0] VEC [11] = '{
    {32'h0000_1004, 2'b10, 1'b0},  // R1 cold miss
    {32'h0000_1006, 2'b01, 1'b1},  // R3 upper halfword
    {32'h0000_1007, 2'b00, 1'b1},  // R3 top byte
    {32'h0000_103C, 2'b11, 1'b1},  // R3 last word of line, alt word code
    {32'h0000_1404, 2'b10, 1'b0},  // R5 same index, other tag
    {32'h0000_1000, 2'b00, 1'b0},  // R5 evicted line
    {32'h0000_2041, 2'b00, 1'b0},  // R5 index 1 cold
    {32'h0000_2043, 2'b01, 1'b1},  // R3 halfword ignores bit 0
    {32'h0000_1010, 2'b10, 1'b1},  // R9 refilled line still present
    {32'h8000_207C, 2'b10, 1'b0},  // R5 tag differs in MSB
    {32'h0000_2042, 2'b00, 1'b0}   // R5 index 1 evicted again
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", 32'(busy), 32'd0);
    check(spec_valid == 1'b0, "R1 spec_valid", 32'(spec_valid), 32'd0);
    check(chk_hit == 1'b0, "R1 chk_hit", 32'(chk_hit), 32'd0);
    check(replay == 1'b0, "R1 replay", 32'(replay), 32'd0);
    check(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 11; k++) begin
      logic [34:0] v;
      v = VEC[k];
      do_load(v[34:3], v[2:1], v[0]);
    end

    // R8: hit queued right behind a miss is dropped; R7: request during refill ignored
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_0140; req_size = 2'b10;   // index 5, cold
    @(negedge clk);
    req_addr = 32'h0000_1010;                                        // would hit
    @(negedge clk);
    req_valid = 1'b0;
    check(replay == 1'b1, "R5 r8_miss replay", 32'(replay), 32'd1);
    check(spec_valid == 1'b1, "R2 r8_young spec", 32'(spec_valid), 32'd1);
    @(negedge clk);
    check(!chk_hit && !replay, "R8 younger dropped", {30'd0, chk_hit, replay}, 32'd0);
    req_valid = 1'b1; req_addr = 32'h0000_1010;
    @(negedge clk);
    req_valid = 1'b0;
    check(spec_valid == 1'b0, "R7 ignored while busy", 32'(spec_valid), 32'd0);
    while (busy) @(negedge clk);
    one_access(32'h0000_0144, 2'b00, 1'b1);  // R9 neighbour in refilled line

    // R10: three back-to-back hits
    req_valid = 1'b1; req_addr = 32'h0000_1000; req_size = 2'b10;
    @(negedge clk);
    check(spec_data == mem_word(32'h1000), "R10 data A", spec_data, mem_word(32'h1000));
    req_addr = 32'h0000_1005; req_size = 2'b00;
    @(negedge clk);
    check(chk_hit == 1'b1, "R10 hit A", 32'(chk_hit), 32'd1);
    check(spec_data == expect_load(32'h1005, 2'b00), "R10 data B", spec_data,
          expect_load(32'h1005, 2'b00));
    req_addr = 32'h0000_100A; req_size = 2'b01;
    @(negedge clk);
    req_valid = 1'b0;
    check(chk_hit == 1'b1, "R10 hit B", 32'(chk_hit), 32'd1);
    check(spec_data == expect_load(32'h100A, 2'b01), "R10 data C", spec_data,
          expect_load(32'h100A, 2'b01));
    @(negedge clk);
    check(chk_hit == 1'b1 && replay == 1'b0, "R10 hit C", {30'd0, chk_hit, replay}, 32'd2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule